// File: doc/BRIEF.md
# Two-Line Maskable Interrupt Controller

This block gathers one-cycle event pulses from internal sources and turns them into two active-low interrupt request lines for a host processor. The events come from four groups of eight. Typical sources are a write attempted while a transmit FIFO is full, an arithmetic overflow in a filter, and a codec asking for its next sample. Each event sets a sticky bit in its group's status register.

Every status register has a mask register of the same width. A mask bit at 1 lets its status bit request an interrupt. A routing register holds two enables per status register, one for each request line. A request line is pulled low while at least one routed register has a bit that is both set and unmasked. The host reads the status registers to find the cause. A read returns the value and clears the register.

All masks and routes reset to zero, so no request can assert after reset. Each line is driven by a small two-state machine. The states are `PIN_QUIET` (line high) and `PIN_ACTIVE` (line low). The transition `RAISE` goes from quiet to active when an unmasked routed cause is pending. The transition `RELEASE` returns to quiet once no such cause remains. Because the line is taken from the state register, it is glitch free.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset both `irq_n` bits are 1, and every status, mask and routing register reads 0.
- R2: Address map: 0..3 are status registers 0..3 (read only), 4..7 are mask registers 0..3 (read/write), and 8 is the routing register (read/write, 8 bits). A write to 0..3 has no effect. Any address from 9 to 15 reads 0.
- R3: Routing bit 2*i enables status register i onto `irq_n[0]`, and bit 2*i+1 enables it onto `irq_n[1]`.
- R4: A mask bit at 1 enables its status bit and a mask bit at 0 blocks it. Because masks reset to 0, events arriving after reset leave both lines high.
- R5: A status bit stays set until its register is read, whatever the mask and routing settings are.
- R6: A read of a status register (`reg_cs`=1, `reg_we`=0) returns the current value in the same cycle and clears the register at the next clock edge. An event arriving in that same cycle still leaves its bit set.
- R7: `irq_n[p]` equals 0 one clock edge after any register routed to line p holds a bit that is both set and unmasked, and equals 1 one edge after no such bit remains.
- R8: Bit `i*8+b` of `evt` is sampled at a clock edge and sets bit b of status register i at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the addressed register |
| evt | input | 32 | One-cycle event pulses, four groups of eight |
| irq_n | output | 2 | Active-low interrupt request lines |

## Verification
The read-clear of a status register and a new event on the same register can fall in the same clock cycle. The new event must survive the clear. This case is provoked directly: a status register is read while an event pulse is driven on one of its bits. The random phase also mixes reads with event pulses, so collisions occur there too. The case is judged in three ways. The read data must show the old value. A later read must show the new bit. The request line must stay low throughout, as a reference model computed in the bench predicts.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_NREG  = 4;
    localparam int IRQ_WIDTH = 8;
    localparam int IRQ_AW    = 4;
    localparam int IRQ_PINS  = 2;

    typedef enum logic [0:0] {
        PIN_QUIET  = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask
);
    logic [W-1:0] status_nxt;

    // clear on read first, then new events set bits so none is lost
    always_comb begin
        status_nxt = rd_clr ? '0 : status;
        status_nxt = status_nxt | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= status_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= mask_wdata;
        end
    end
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge #(
    parameter int NREG = 4,
    parameter int W    = 8,
    parameter int PINS = 2
) (
    input  logic [NREG*W-1:0]    status_flat,
    input  logic [NREG*W-1:0]    mask_flat,
    input  logic [NREG*PINS-1:0] route,
    output logic [PINS-1:0]      pending
);
    logic [NREG-1:0] reg_hot;

    genvar gi, gp;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            assign reg_hot[gi] = |(status_flat[gi*W +: W] & mask_flat[gi*W +: W]);
        end
        for (gp = 0; gp < PINS; gp++) begin : g_pin
            logic [NREG-1:0] sel;
            for (gi = 0; gi < NREG; gi++) begin : g_sel
                assign sel[gi] = reg_hot[gi] & route[gi*PINS + gp];
            end
            assign pending[gp] = |sel;
        end
    endgenerate
endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_n
);
    pin_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PIN_QUIET:  if (pending)  state_nxt = PIN_ACTIVE; // RAISE
            PIN_ACTIVE: if (!pending) state_nxt = PIN_QUIET;  // RELEASE
            default:    state_nxt = PIN_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PIN_QUIET;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        unique case (state)
            PIN_ACTIVE: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NREG = IRQ_NREG,
    parameter int W    = IRQ_WIDTH,
    parameter int AW   = IRQ_AW,
    parameter int PINS = IRQ_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_cs,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [W-1:0]        reg_wdata,
    output logic [W-1:0]        reg_rdata,
    input  logic [NREG*W-1:0]   evt,
    output logic [PINS-1:0]     irq_n
);
    localparam int RW        = NREG * PINS;
    localparam int MASK_BASE = NREG;
    localparam int ROUTE_ADR = 2 * NREG;

    logic [NREG*W-1:0] status_flat;
    logic [NREG*W-1:0] mask_flat;
    logic [NREG-1:0]   clr_vec;
    logic [NREG-1:0]   mask_we_vec;
    logic [RW-1:0]     route;
    logic [PINS-1:0]   pending;
    logic [W-1:0]      route_rd;
    logic              rd_cycle;
    logic              wr_cycle;

    assign rd_cycle = reg_cs && !reg_we;
    assign wr_cycle = reg_cs &&  reg_we;

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_bank
            assign clr_vec[gi]     = rd_cycle && (int'(reg_addr) == gi);
            assign mask_we_vec[gi] = wr_cycle && (int'(reg_addr) == MASK_BASE + gi);

            irq_status_bank #(.W(W)) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .evt        (evt[gi*W +: W]),
                .rd_clr     (clr_vec[gi]),
                .mask_we    (mask_we_vec[gi]),
                .mask_wdata (reg_wdata),
                .status     (status_flat[gi*W +: W]),
                .mask       (mask_flat[gi*W +: W])
            );
        end

        if (RW < W) begin : g_rpad
            assign route_rd = {{(W-RW){1'b0}}, route};
        end else begin : g_rfull
            assign route_rd = route[W-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route <= '0;
        end else if (wr_cycle && (int'(reg_addr) == ROUTE_ADR)) begin
            route <= reg_wdata[RW-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(reg_addr) == i)             reg_rdata = status_flat[i*W +: W];
            if (int'(reg_addr) == MASK_BASE + i) reg_rdata = mask_flat[i*W +: W];
        end
        if (int'(reg_addr) == ROUTE_ADR) reg_rdata = route_rd;
    end

    irq_route_merge #(.NREG(NREG), .W(W), .PINS(PINS)) u_merge (
        .status_flat (status_flat),
        .mask_flat   (mask_flat),
        .route       (route),
        .pending     (pending)
    );

    genvar gp;
    generate
        for (gp = 0; gp < PINS; gp++) begin : g_pin
            irq_pin_fsm u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .pending (pending[gp]),
                .irq_n   (irq_n[gp])
            );
        end
    endgenerate
endmodule

// File: rtl/irq_checker.sv
module irq_checker #(
    parameter int NREG = 4,
    parameter int W    = 8,
    parameter int PINS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREG*W-1:0] evt,
    input logic [NREG*W-1:0] status_flat,
    input logic [NREG*W-1:0] mask_flat,
    input logic [NREG-1:0]   clr_vec,
    input logic [PINS-1:0]   pending,
    input logic [PINS-1:0]   irq_n
);
    logic [NREG*W-1:0] clr_wide;
    always_comb begin
        for (int i = 0; i < NREG; i++) clr_wide[i*W +: W] = {W{clr_vec[i]}};
    end

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_flat == '0) |=> (irq_n == {PINS{1'b1}})); // R4

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_flat & $past(status_flat & ~clr_wide)) == $past(status_flat & ~clr_wide))); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status_flat & $past(evt)) == $past(evt))); // R6

    AST_PIN0_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n[0] == !$past(pending[0]))); // R7

    AST_PIN1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n[1] == !$past(pending[1]))); // R7
endmodule

bind dual_irq_ctrl irq_checker #(.NREG(NREG), .W(W), .PINS(PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .status_flat (status_flat),
    .mask_flat   (mask_flat),
    .clr_vec     (clr_vec),
    .pending     (pending),
    .irq_n       (irq_n)
);

// File: tb/dual_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dual_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_cs = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [31:0] evt = '0;
    logic [1:0]  irq_n;

    int n_chk = 0, n_bad = 0;
    logic [7:0] m_stat [4];
    logic [7:0] m_mask [4];
    logic [7:0] m_route;

    always #5 clk = ~clk;

    dual_irq_ctrl u_dual_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt(evt), .irq_n(irq_n));

    function automatic logic pend(input int p);
        logic r = 1'b0;
        for (int i = 0; i < 4; i++)
            if (m_route[2*i+p] && ((m_stat[i] & m_mask[i]) != 0)) r = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        if (a < 4) return m_stat[a];
        if (a < 8) return m_mask[a-4];
        if (a == 8) return m_route;
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // called just after a falling edge; ends just after the next falling edge
    task automatic step(input bit cs, input bit we, input logic [3:0] a,
                        input logic [7:0] d, input logic [31:0] e);
        logic [1:0] exp_n;
        reg_cs = cs; reg_we = we; reg_addr = a; reg_wdata = d; evt = e;
        #1;
        if (cs && !we) begin
            if (a < 4) check(reg_rdata == model_read(a), "R6 read value", reg_rdata, model_read(a));
            else       check(reg_rdata == model_read(a), "R2 read value", reg_rdata, model_read(a));
        end
        exp_n = {~pend(1), ~pend(0)};
        @(posedge clk);
        if (cs && we) begin
            if (a >= 4 && a < 8) m_mask[a-4] = d;
            if (a == 8) m_route = d;
        end
        if (cs && !we && a < 4) m_stat[a] = 8'h00;
        for (int i = 0; i < 4; i++) m_stat[i] |= e[i*8 +: 8];
        @(negedge clk);
        check(irq_n == exp_n, "R7 irq_n", irq_n, exp_n);
        reg_cs = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [3:0] a); step(1, 0, a, 0, 0); endtask
    task automatic wr(input logic [3:0] a, input logic [7:0] d); step(1, 1, a, d, 0); endtask
    task automatic idle(); step(0, 0, 0, 0, 0); endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(2024);
        for (int i = 0; i < 4; i++) begin m_stat[i] = 0; m_mask[i] = 0; end
        m_route = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq_n == 2'b11, "R1 irq_n after reset", irq_n, 2'b11);
        for (int a = 0; a < 9; a++) begin
            reg_addr = 4'(a); #1;
            check(reg_rdata == 8'h00, "R1 register reset value", reg_rdata, 0);
        end

        // R4 masked at reset: every event fires, lines stay high
        step(0, 0, 0, 0, 32'hFFFF_FFFF);
        wr(8, 8'hFF);
        idle(); idle();
        check(irq_n == 2'b11, "R4 masked events keep lines high", irq_n, 2'b11);
        // R8 bit positions, R5 sticky through idle
        for (int i = 0; i < 4; i++) rd(4'(i));
        check(m_stat[0] == 0, "R6 model cleared", m_stat[0], 0);
        step(0, 0, 0, 0, 32'h0000_0400); // reg1 bit2
        idle(); idle(); idle();
        reg_addr = 4'd1; #1;
        check(reg_rdata == 8'h04, "R8 event bit lands in reg1 bit2", reg_rdata, 8'h04);
        check(reg_rdata == 8'h04, "R5 bit held through idle cycles", reg_rdata, 8'h04);
        rd(1);
        reg_addr = 4'd1; #1;
        check(reg_rdata == 8'h00, "R6 cleared after read", reg_rdata, 0);

        // R3 reg0 routed to pin1 only
        wr(8, 8'b0000_0010);
        wr(4, 8'h01);
        step(0, 0, 0, 0, 32'h0000_0001);
        idle();
        check(irq_n == 2'b01, "R3 reg0 drives only irq_n[1]", irq_n, 2'b01);
        // R6 collision: read and new event together
        step(1, 0, 0, 0, 32'h0000_0001);
        reg_addr = 4'd0; #1;
        check(reg_rdata == 8'h01, "R6 event beats read clear", reg_rdata, 8'h01);
        idle();
        check(irq_n == 2'b01, "R6 line stays low after collision", irq_n, 2'b01);
        rd(0); idle();
        check(irq_n == 2'b11, "R7 released after clear", irq_n, 2'b11);

        // R2 write to status ignored, unmapped reads zero
        step(0, 0, 0, 0, 32'h0000_0000);
        wr(2, 8'hFF);
        reg_addr = 4'd2; #1;
        check(reg_rdata == 8'h00, "R2 status write ignored", reg_rdata, 0);
        wr(12, 8'h5A);
        reg_addr = 4'd12; #1;
        check(reg_rdata == 8'h00, "R2 unmapped address reads 0", reg_rdata, 0);
        wr(5, 8'hA5);
        reg_addr = 4'd5; #1;
        check(reg_rdata == 8'hA5, "R2 mask readback", reg_rdata, 8'hA5);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int kind = $urandom_range(0, 9);
            logic [31:0] e = '0;
            if ($urandom_range(0, 3) == 0) e = 32'(1) << $urandom_range(0, 31);
            if (kind < 3)       step(1, 0, 4'($urandom_range(0, 9)), 0, e);
            else if (kind == 3) step(1, 1, 4'($urandom_range(4, 8)), 8'($urandom), e);
            else                step(0, 0, 0, 0, e);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule